// File: doc/BRIEF.md
# Comparator Interrupt Channel for an Event Timer

This block is one channel of a multi-channel event timer. It watches a shared free-running main counter, which it does not own, and compares it with its own comparator register. When they are equal the channel raises an interrupt in one of three forms:

- a one-cycle pulse on its selected output line;
- a level held in the channel's status bit until software clears it;
- a message write, an address and data pair, handed out over a valid/ready port.

In one-shot mode the comparator stays where software put it. In periodic mode it moves forward by a programmed period after every match. Software programs the channel through three write strobes (configuration, comparator, message route) that share one 64-bit data bus. It clears the level status through a separate write-1-to-clear strobe.

The message port obeys valid/ready rules. When a message is produced, `msg_valid` rises and stays high, with `msg_addr` and `msg_data` held stable, until a cycle in which `msg_ready` is high. The transfer completes on that clock edge. A match that would produce a new message while an earlier one is still waiting is dropped. No queue is kept.

The configuration register has a fixed layout. The output line number sits in bits 13:9, because the interrupt controller next to the block decodes it there. The allowed-line mask sits in bits 63:32.

Top module: `tmr_chan`

## Requirements
- R1: After reset the configuration reads {ALLOW_MASK, 32'h0000_8010}, meaning periodic-capable (bit 4) and message-capable (bit 15) are set. The comparator reads 32'hFFFF_FFFF. Status, `irq_pulse` and `msg_valid` are 0.
- R2: A configuration write keeps only these bits of the data:
  - level mode, bit 1 (0 = edge, 1 = level);
  - interrupt enable, bit 2;
  - periodic, bit 3;
  - value-set, bit 6;
  - line number, bits 13:9;
  - message enable, bit 14.

  Bits 63:32, bit 15 and bit 4 keep their fixed values. Bit 8 (32-bit mode), bit 5 and every other bit read 0.
- R3: A nonzero line number whose bit is clear in ALLOW_MASK is replaced by 0. Line 0 means not connected. `irq_line` always shows bits 13:9.
- R4: A match occurs when `cnt_run` and `tick` are high and `cnt_val` equals the comparator on a clock edge. The resulting interrupt appears one clock later. It is still issued if `cnt_run` falls right after the match.
- R5: In one-shot mode a comparator write loads the comparator directly. A value the counter has already passed fires only after the counter wraps around.
- R6: In periodic mode a comparator write loads the period. It loads the comparator as well only when value-set (bit 6) is 1. Any comparator write clears value-set.
- R7: In periodic mode each match advances the comparator by the period.
- R8: While the periodic bit is 0 the period register is held at zero. Setting the periodic bit again does not restore the old period.
- R9: No pulse, status or message is produced while interrupt enable (bit 2) is 0.
- R10: A delivered match on a connected line does one of two things:
  - in edge mode it gives a one-cycle `irq_pulse`;
  - in level mode it sets `status`, which stays set.

  A match while `status` is already set has no effect.
- R11: Writing with `sts_clr_we` and `sts_clr_bit`=1 clears `status`. Writing `sts_clr_bit`=0 has no effect.
- R12: A configuration write clears a set `status` if the new setting meets any of these:
  - disables the interrupt;
  - selects edge mode;
  - enables messages;
  - changes the line.

  A write that changes none of these leaves `status` set.
- R13: When message enable is set, a delivered match produces a message instead of a line interrupt, even with line 0. The address is route bits 63:32 and the data is route bits 31:0. The message is held, stable, until `msg_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_val | input | CNT_W | Shared main counter value |
| cnt_run | input | 1 | Main counter enabled |
| tick | input | 1 | Counter advance qualifier for this cycle |
| cfg_we | input | 1 | Write configuration register |
| cmp_we | input | 1 | Write comparator/period (low CNT_W bits of wdata) |
| rte_we | input | 1 | Write message route register |
| wdata | input | 64 | Write data |
| sts_clr_we | input | 1 | Status write strobe |
| sts_clr_bit | input | 1 | Status write data, 1 clears |
| cfg_q | output | 64 | Configuration register |
| cmp_q | output | CNT_W | Comparator register |
| rte_q | output | 64 | Message route register |
| status | output | 1 | Level status, also the held level on the line |
| irq_line | output | 5 | Selected output line number |
| irq_pulse | output | 1 | Edge-mode one-cycle pulse |
| msg_valid | output | 1 | Message waiting |
| msg_ready | input | 1 | Message taken on this edge when high |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The hardest situation to reach is a one-shot comparator that the counter has already passed. It must stay silent until the counter wraps. The stimulus drives the counter from just below its maximum across the wrap and checks that exactly one pulse appears at the programmed value. A second hard case is a match followed at once by the counter stopping. The bench presents a single matching cycle, drops `cnt_run` and `tick` straight after, and still expects the pulse. Periodic sweeps count pulses over a counter window and compare the count and the final comparator with arithmetic on the start value and the period.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int B_LVL  = 1;
  localparam int B_IEN  = 2;
  localparam int B_PER  = 3;
  localparam int B_VSET = 6;
  localparam int B_RTE  = 9;
  localparam int RTE_W  = 5;
  localparam int B_MEN  = 14;
  localparam int B_MCAP = 15;
  localparam logic [63:0] WR_MASK = 64'h0000_0000_0000_7E4E;
  localparam logic [63:0] RO_LOW  = 64'h0000_0000_0000_8010;
endpackage

// File: rtl/tmr_cfg_reg.sv
module tmr_cfg_reg
  import tmr_pkg::*;
#(
  parameter logic [31:0] ALLOW_MASK = 32'h00F0_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [63:0] wdata,
  input  logic        cmp_we,
  input  logic        status,
  output logic [63:0] cfg,
  output logic        drop_lvl
);
  localparam logic [63:0] RO_ALL = {ALLOW_MASK, 32'h0} | RO_LOW;

  logic [63:0]      cand;
  logic [RTE_W-1:0] r_new;

  always_comb begin
    cand  = (wdata & WR_MASK) | RO_ALL;
    r_new = cand[B_RTE +: RTE_W];
    if (r_new != '0 && !ALLOW_MASK[r_new])
      cand[B_RTE +: RTE_W] = '0;
  end

  assign drop_lvl = cfg_we && status &&
                    (!cand[B_IEN] || !cand[B_LVL] || (cand[B_MEN] && cand[B_MCAP]) ||
                     cand[B_RTE +: RTE_W] != cfg[B_RTE +: RTE_W]);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cfg <= RO_ALL;
    else if (cfg_we)
      cfg <= cand;
    else if (cmp_we)
      cfg[B_VSET] <= 1'b0;
  end

  AST_VSET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we && !cfg_we) |=> !cfg[B_VSET]);  // R6
  AST_RO_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg[63:32] == ALLOW_MASK && cfg[B_MCAP] && cfg[4] && !cfg[8] && !cfg[5]));  // R2
  AST_ROUTE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg[B_RTE +: RTE_W] == '0 || ALLOW_MASK[cfg[B_RTE +: RTE_W]]));  // R3
endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             periodic,
  input  logic             vset,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_run,
  input  logic             tick,
  output logic [CNT_W-1:0] cmp_q,
  output logic             hit_q
);
  logic [CNT_W-1:0] period;
  logic             match;

  assign match = cnt_run && tick && (cnt_val == cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '1;
      period <= '0;
      hit_q  <= 1'b0;
    end else begin
      hit_q <= match;
      if (!periodic)
        period <= '0;
      else if (cmp_we)
        period <= cmp_wdata;
      if (cmp_we) begin
        if (!periodic || vset)
          cmp_q <= cmp_wdata;
      end else if (match && periodic) begin
        cmp_q <= cmp_q + period;
      end
    end
  end

  AST_PERIOD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !periodic |=> (period == '0));  // R8
  AST_HIT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_run && tick && cnt_val == cmp_q) |=> hit_q);  // R4
endmodule

// File: rtl/tmr_irq_out.sv
module tmr_irq_out
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             ien,
  input  logic             lvl,
  input  logic             msg_on,
  input  logic [RTE_W-1:0] line,
  input  logic [63:0]      rte,
  input  logic             sts_clr,
  input  logic             drop_lvl,
  input  logic             msg_ready,
  output logic             status,
  output logic             irq_pulse,
  output logic             msg_valid,
  output logic [31:0]      msg_addr,
  output logic [31:0]      msg_data
);
  logic fire, to_msg, to_line;

  assign fire    = hit && ien && !status;
  assign to_msg  = fire && msg_on;
  assign to_line = fire && !msg_on && (line != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status    <= 1'b0;
      irq_pulse <= 1'b0;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      irq_pulse <= to_line && !lvl;
      if (to_line && lvl)
        status <= 1'b1;
      else if (sts_clr || drop_lvl)
        status <= 1'b0;
      if (msg_valid && msg_ready)
        msg_valid <= 1'b0;
      if (to_msg && (!msg_valid || msg_ready)) begin
        msg_valid <= 1'b1;
        msg_addr  <= rte[63:32];
        msg_data  <= rte[31:0];
      end
    end
  end

  AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(ien));  // R9
  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !sts_clr && !drop_lvl) |=> status);  // R10
  AST_MSG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));  // R13
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int          CNT_W      = 32,
  parameter logic [31:0] ALLOW_MASK = 32'h00F0_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_run,
  input  logic             tick,
  input  logic             cfg_we,
  input  logic             cmp_we,
  input  logic             rte_we,
  input  logic [63:0]      wdata,
  input  logic             sts_clr_we,
  input  logic             sts_clr_bit,
  output logic [63:0]      cfg_q,
  output logic [CNT_W-1:0] cmp_q,
  output logic [63:0]      rte_q,
  output logic             status,
  output logic [RTE_W-1:0] irq_line,
  output logic             irq_pulse,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [31:0]      msg_addr,
  output logic [31:0]      msg_data
);
  logic drop_lvl, hit;

  always_ff @(posedge clk) begin
    if (!rst_n)
      rte_q <= '0;
    else if (rte_we)
      rte_q <= wdata;
  end

  assign irq_line = cfg_q[B_RTE +: RTE_W];

  tmr_cfg_reg #(.ALLOW_MASK(ALLOW_MASK)) i_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .wdata(wdata), .cmp_we(cmp_we),
    .status(status), .cfg(cfg_q), .drop_lvl(drop_lvl)
  );

  tmr_cmp_unit #(.CNT_W(CNT_W)) i_cmp (
    .clk(clk), .rst_n(rst_n), .periodic(cfg_q[B_PER]), .vset(cfg_q[B_VSET]),
    .cmp_we(cmp_we), .cmp_wdata(wdata[CNT_W-1:0]), .cnt_val(cnt_val),
    .cnt_run(cnt_run), .tick(tick), .cmp_q(cmp_q), .hit_q(hit)
  );

  tmr_irq_out i_out (
    .clk(clk), .rst_n(rst_n), .hit(hit), .ien(cfg_q[B_IEN]), .lvl(cfg_q[B_LVL]),
    .msg_on(cfg_q[B_MEN] && cfg_q[B_MCAP]), .line(irq_line), .rte(rte_q),
    .sts_clr(sts_clr_we && sts_clr_bit), .drop_lvl(drop_lvl), .msg_ready(msg_ready),
    .status(status), .irq_pulse(irq_pulse), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  AST_STATUS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr_we && sts_clr_bit && !hit) |=> !status);  // R11
endmodule

// File: tb/test_tmr_chan.sv
module test_tmr_chan;
  localparam logic [31:0] ALLOW = 32'h00F0_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cnt_val = '0;
  logic        cnt_run = 1'b0, tick = 1'b0;
  logic        cfg_we = 1'b0, cmp_we = 1'b0, rte_we = 1'b0;
  logic [63:0] wdata = '0;
  logic        sts_clr_we = 1'b0, sts_clr_bit = 1'b0, msg_ready = 1'b0;
  logic [63:0] cfg_q, rte_q;
  logic [31:0] cmp_q, msg_addr, msg_data;
  logic        status, irq_pulse, msg_valid;
  logic [4:0]  irq_line;

  int total = 0, bad = 0, pulses = 0, hs = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tmr_chan #(.CNT_W(32), .ALLOW_MASK(ALLOW)) i_tmr_chan (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_run(cnt_run), .tick(tick),
    .cfg_we(cfg_we), .cmp_we(cmp_we), .rte_we(rte_we), .wdata(wdata),
    .sts_clr_we(sts_clr_we), .sts_clr_bit(sts_clr_bit), .cfg_q(cfg_q), .cmp_q(cmp_q),
    .rte_q(rte_q), .status(status), .irq_line(irq_line), .irq_pulse(irq_pulse),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_cfg(input logic [63:0] d);
    logic [63:0] e;
    logic [4:0]  r;
    e = (d & 64'h7E4E) | 64'h8010 | {ALLOW, 32'h0};
    r = d[13:9];
    if (r != 0 && !ALLOW[r]) e[13:9] = 5'd0;
    return e;
  endfunction

  task automatic cyc();
    if (msg_valid && msg_ready) hs++;
    @(posedge clk);
    @(negedge clk);
    pulses += int'(irq_pulse);
  endtask

  task automatic wr_cfg(input logic [63:0] d);
    cfg_we = 1'b1; wdata = d; cyc(); cfg_we = 1'b0;
  endtask

  task automatic wr_cmp(input logic [31:0] d);
    cmp_we = 1'b1; wdata = {32'h0, d}; cyc(); cmp_we = 1'b0;
  endtask

  task automatic sts_wr(input logic b);
    sts_clr_we = 1'b1; sts_clr_bit = b; cyc(); sts_clr_we = 1'b0;
  endtask

  task automatic run(input logic [31:0] start, input int n);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      cnt_val = start + 32'(i); cnt_run = 1'b1; tick = 1'b1; cyc();
    end
    tick = 1'b0;
    repeat (3) cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    check("R1 cfg", cfg_q, {ALLOW, 32'h0000_8010});
    check("R1 cmp", {32'h0, cmp_q}, 64'hFFFF_FFFF);
    check("R1 status/pulse/msg", {61'h0, status, irq_pulse, msg_valid}, 64'h0);

    // R2 R3 sweep of every line number with all other bits set
    for (int r = 0; r < 32; r++) begin
      logic [63:0] d;
      d = (64'hFFFF_FFFF_FFFF_FFFF & ~64'h3E00) | (64'(r) << 9);
      wr_cfg(d);
      check($sformatf("R2_R3 cfg line %0d", r), cfg_q, exp_cfg(d));
      check("R3 irq_line", {59'h0, irq_line}, {59'h0, exp_cfg(d)[13:9]});
    end
    wr_cfg(64'h0);
    check("R2 zero write", cfg_q, exp_cfg(64'h0));

    // R5 one-shot edge on line 21
    wr_cfg(64'h2A04);
    wr_cmp(32'd100);
    check("R5 direct load", {32'h0, cmp_q}, 64'd100);
    run(32'd90, 20);
    check("R10 edge pulse count", 64'(pulses), 64'd1);
    check("R5 cmp unchanged", {32'h0, cmp_q}, 64'd100);
    check("R10 edge no status", {63'h0, status}, 64'h0);

    // R4 gating by tick and run
    pulses = 0;
    cnt_val = 32'd100; cnt_run = 1'b1; tick = 1'b0; repeat (4) cyc();
    cnt_run = 1'b0; tick = 1'b1; repeat (4) cyc();
    tick = 1'b0; repeat (3) cyc();
    check("R4 no match without tick/run", 64'(pulses), 64'd0);

    // R5 passed value waits for wrap
    wr_cmp(32'd150);
    run(32'd200, 50);
    check("R5 passed value silent", 64'(pulses), 64'd0);
    run(32'hFFFF_FFF0, 200);
    check("R5 fires after wrap", 64'(pulses), 64'd1);

    // R6 R7 periodic
    wr_cfg(64'h2A04 | 64'h8 | 64'h40);
    wr_cmp(32'd1000);
    check("R6 vset loads cmp", {32'h0, cmp_q}, 64'd1000);
    check("R6 vset self-clears", {63'h0, cfg_q[6]}, 64'h0);
    wr_cmp(32'd7);
    check("R6 period-only write", {32'h0, cmp_q}, 64'd1000);
    run(32'd995, 40);
    check("R7 periodic count", 64'(pulses), 64'((1034 - 1000) / 7 + 1));
    check("R7 cmp advanced", {32'h0, cmp_q}, 64'(1000 + ((1034 - 1000) / 7 + 1) * 7));

    // R8 period forced to zero
    wr_cfg(64'h2A04);
    wr_cfg(64'h2A0C);
    run(32'd1030, 20);
    check("R8 period zero count", 64'(pulses), 64'd1);
    check("R8 cmp stays", {32'h0, cmp_q}, 64'd1035);

    // R9 enable off
    wr_cfg(64'h2A00);
    wr_cmp(32'd500);
    run(32'd495, 10);
    check("R9 disabled no pulse", 64'(pulses), 64'd0);
    check("R9 disabled no status", {63'h0, status}, 64'h0);

    // R10 R11 level
    wr_cfg(64'h2A06);
    wr_cmp(32'd600);
    run(32'd595, 10);
    check("R10 level sets status", {63'h0, status}, 64'h1);
    check("R10 level no pulse", 64'(pulses), 64'd0);
    wr_cmp(32'd610);
    run(32'd605, 10);
    check("R10 repeat match keeps status", {63'h0, status}, 64'h1);
    sts_wr(1'b0);
    check("R11 write 0 no effect", {63'h0, status}, 64'h1);
    sts_wr(1'b1);
    check("R11 write 1 clears", {63'h0, status}, 64'h0);

    // R12 drop rules
    run(32'd605, 10);
    wr_cfg(64'h2A06);
    check("R12 same config keeps", {63'h0, status}, 64'h1);
    wr_cfg(64'h2C06);
    check("R12 route change drops", {63'h0, status}, 64'h0);
    run(32'd605, 10);
    check("R12 set on line 22", {63'h0, status}, 64'h1);
    wr_cfg(64'h2C04);
    check("R12 edge drops", {63'h0, status}, 64'h0);
    wr_cfg(64'h2C06);
    run(32'd605, 10);
    wr_cfg(64'h2C02);
    check("R12 disable drops", {63'h0, status}, 64'h0);
    wr_cfg(64'h2C06);
    run(32'd605, 10);
    wr_cfg(64'h6C06);
    check("R12 message drops", {63'h0, status}, 64'h0);

    // R4 counter stopped right after match
    wr_cfg(64'h2A04);
    wr_cmp(32'd700);
    pulses = 0;
    cnt_val = 32'd700; cnt_run = 1'b1; tick = 1'b1; cyc();
    cnt_run = 1'b0; tick = 1'b0; repeat (3) cyc();
    check("R4 issued after stop", 64'(pulses), 64'd1);

    // R13 message
    rte_we = 1'b1; wdata = 64'hFEE0_1000_0000_0041; cyc(); rte_we = 1'b0;
    check("R13 route reg", rte_q, 64'hFEE0_1000_0000_0041);
    wr_cfg(64'h4004);
    wr_cmp(32'd800);
    msg_ready = 1'b0; hs = 0;
    run(32'd795, 10);
    repeat (4) cyc();
    check("R13 valid held", {63'h0, msg_valid}, 64'h1);
    check("R13 addr/data", {msg_addr, msg_data}, 64'hFEE0_1000_0000_0041);
    check("R13 no pulse/status", {62'h0, status, pulses != 0}, 64'h0);
    msg_ready = 1'b1; cyc();
    check("R13 one handshake", 64'(hs), 64'd1);
    check("R13 valid dropped", {63'h0, msg_valid}, 64'h0);
    msg_ready = 1'b0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule